// File: doc/BRIEF.md
# Two-Operand Compute Unit with Per-Port Request/Grant Handshake

This block is one function unit of an out-of-order core. An issue pulse with a 2-bit opcode starts an operation and the unit becomes busy. It then asks an external scheduler for its two source operands, using one request line per read port. It takes each operand from that port's source data input in the cycle its grant arrives. When every operand it needs is held, it raises a write request. In the cycle the write grant arrives it drives the ALU result onto its output bus, and it then goes idle.

Each port obeys a strict pulse discipline. A request may be granted in the cycle it rises or any number of cycles later. Each grant lasts exactly one cycle. The request falls one cycle after the grant and stays low for the rest of the operation. An issue-time flag can force operand A to zero. In that case the unit never asks for read port A.

Top module: `opCompUnit`

## Requirements
- R1: `issueI` seen while `busyO` is low makes `busyO` high in the next cycle. In that same cycle `rdReqO[1]` (operand B) rises, and so does `rdReqO[0]` (operand A) unless `zeroAI` was set at issue.
- R2: `issueI` seen while `busyO` is high has no effect. The operation in flight keeps its opcode, its zero flag and its operands.
- R3: A read grant `rdGntI[p]` seen while `rdReqO[p]` is high captures that port's source input (`srcAI` for p=0, `srcBI` for p=1) in that cycle. The grant may come in the first cycle of the request or in any later cycle.
- R4: `rdReqO[p]` goes low exactly one cycle after its grant and stays low until `busyO` falls.
- R5: The two read grants may arrive in either order or in the same cycle, with the same result.
- R6: `wrReqO` rises in the cycle after the last required operand is captured. It is never high while any `rdReqO` bit is high.
- R7: `resultO` carries the result in the cycle where `wrGntI` and `wrReqO` are both high, and is zero in every other cycle. The result is taken modulo 2^W. Opcodes: 00 = A+B, 01 = A-B, 10 = A AND B, 11 = A OR B.
- R8: After a write grant is seen, both `wrReqO` and `busyO` are low in the next cycle.
- R9: With `zeroAI` set at issue, operand A is zero and `rdReqO[0]` never rises during that operation.
- R10: A grant on a port whose request is low is ignored. It captures no data and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| issueI | input | 1 | Issue pulse, honoured only while idle |
| opI | input | 2 | Opcode, latched at issue |
| zeroAI | input | 1 | Force operand A to zero, latched at issue |
| busyO | output | 1 | Operation in flight |
| rdReqO | output | 2 | Read requests: bit 0 = operand A, bit 1 = operand B |
| rdGntI | input | 2 | Read grants, one-cycle pulses, same bit order |
| srcAI | input | W | Source data for operand A |
| srcBI | input | W | Source data for operand B |
| wrReqO | output | 1 | Write request for the result |
| wrGntI | input | 1 | Write grant, one-cycle pulse |
| resultO | output | W | Result bus, non-zero only in the write grant cycle |

## Verification
A request flag that fails to clear, or clears in the wrong cycle, shows on `rdReqO` at the very next sample after the grant. It also delays or advances `wrReqO` by at least a cycle. A wrong operand capture, whether the operand was taken from a spurious grant, from a granted port's later junk data, or while the zero flag was set, shows only later, as a wrong value on `resultO` in the write grant cycle. For that reason every operation drives random junk on the source inputs outside its real grant cycles. A stale opcode, or one overwritten by a late issue, also shows up in that same write grant cycle.

// File: rtl/opcu_pkg.sv
package opcu_pkg;

  localparam int NUM_RD = 2;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_AND = 2'b10,
    OP_OR  = 2'b11
  } aluOpE;

  // strobes from control to datapath
  typedef struct packed {
    logic              issue;
    logic              zeroA;
    logic [NUM_RD-1:0] cap;
    logic              outEn;
  } ctrlStrobeT;

endpackage

// File: rtl/opcu_ctrl.sv
module opcu_ctrl
  import opcu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueI,
  input  logic              zeroAI,
  input  logic [NUM_RD-1:0] rdGntI,
  input  logic              wrGntI,
  output logic              busyO,
  output logic [NUM_RD-1:0] rdReqO,
  output logic              wrReqO,
  output ctrlStrobeT        strobeO
);

  logic busyQ;
  logic wrReqQ;
  logic idleIssue;
  logic wrTake;
  logic [NUM_RD-1:0] haveVec;
  logic [NUM_RD-1:0] takeVec;
  logic allHave;

  assign idleIssue = issueI & ~busyQ;
  assign wrTake    = wrGntI & wrReqQ & busyQ;

  for (genvar p = 0; p < NUM_RD; p++) begin : gRdPort
    logic reqQ;
    logic haveQ;
    logic skipHere;
    logic take;

    // only port 0 may be replaced by the zero immediate
    if (p == 0) begin : gZeroable
      assign skipHere = zeroAI;
    end else begin : gPlain
      assign skipHere = 1'b0;
    end

    assign take = rdGntI[p] & reqQ & busyQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        reqQ  <= 1'b0;
        haveQ <= 1'b0;
      end else if (idleIssue) begin
        reqQ  <= ~skipHere;
        haveQ <= skipHere;
      end else if (take) begin
        reqQ  <= 1'b0;
        haveQ <= 1'b1;
      end
    end

    assign rdReqO[p]  = reqQ;
    assign haveVec[p] = haveQ;
    assign takeVec[p] = take;
  end

  assign allHave = &(haveVec | takeVec);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      wrReqQ <= 1'b0;
    end else if (idleIssue) begin
      busyQ  <= 1'b1;
      wrReqQ <= 1'b0;
    end else if (busyQ) begin
      if (wrTake) begin
        busyQ  <= 1'b0;
        wrReqQ <= 1'b0;
      end else if (!wrReqQ && allHave) begin
        wrReqQ <= 1'b1;
      end
    end
  end

  assign busyO  = busyQ;
  assign wrReqO = wrReqQ;

  always_comb begin
    strobeO       = '0;
    strobeO.issue = idleIssue;
    strobeO.zeroA = zeroAI;
    strobeO.cap   = takeVec;
    strobeO.outEn = wrTake;
  end

endmodule

// File: rtl/opcu_datapath.sv
module opcu_datapath
  import opcu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctrlStrobeT strobeI,
  input  logic [1:0] opI,
  input  logic [W-1:0] srcI [NUM_RD],
  output logic [W-1:0] resultO
);

  aluOpE       opQ;
  logic [W-1:0] opndQ [NUM_RD];
  logic [W-1:0] aluOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) opQ <= OP_ADD;
    else if (strobeI.issue) opQ <= aluOpE'(opI);
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : gOpnd
    logic clearHere;
    if (p == 0) begin : gZeroable
      assign clearHere = strobeI.issue & strobeI.zeroA;
    end else begin : gPlain
      assign clearHere = 1'b0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) opndQ[p] <= '0;
      else if (clearHere) opndQ[p] <= '0;
      else if (strobeI.cap[p]) opndQ[p] <= srcI[p];
    end
  end

  always_comb begin
    unique case (opQ)
      OP_ADD: aluOut = opndQ[0] + opndQ[1];
      OP_SUB: aluOut = opndQ[0] - opndQ[1];
      OP_AND: aluOut = opndQ[0] & opndQ[1];
      OP_OR:  aluOut = opndQ[0] | opndQ[1];
      default: aluOut = '0;
    endcase
  end

  assign resultO = strobeI.outEn ? aluOut : '0;

endmodule

// File: rtl/opCompUnit.sv
module opCompUnit
  import opcu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         issueI,
  input  logic [1:0]   opI,
  input  logic         zeroAI,
  output logic         busyO,
  output logic [1:0]   rdReqO,
  input  logic [1:0]   rdGntI,
  input  logic [W-1:0] srcAI,
  input  logic [W-1:0] srcBI,
  output logic         wrReqO,
  input  logic         wrGntI,
  output logic [W-1:0] resultO
);

  ctrlStrobeT   strobe;
  logic [W-1:0] srcArr [NUM_RD];

  assign srcArr[0] = srcAI;
  assign srcArr[1] = srcBI;

  opcu_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .issueI  (issueI),
    .zeroAI  (zeroAI),
    .rdGntI  (rdGntI),
    .wrGntI  (wrGntI),
    .busyO   (busyO),
    .rdReqO  (rdReqO),
    .wrReqO  (wrReqO),
    .strobeO (strobe)
  );

  opcu_datapath #(.W(W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobeI (strobe),
    .opI     (opI),
    .srcI    (srcArr),
    .resultO (resultO)
  );

endmodule

// File: rtl/opcu_chk.sv
module opcu_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         issueI,
  input logic         zeroAI,
  input logic         busyO,
  input logic [1:0]   rdReqO,
  input logic [1:0]   rdGntI,
  input logic         wrReqO,
  input logic         wrGntI,
  input logic [W-1:0] resultO
);

  // R1
  busy_on_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueI && !busyO) |=> (busyO && rdReqO[1]));

  // R4
  req_a_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReqO[0] && rdGntI[0]) |=> !rdReqO[0]);

  // R4
  req_b_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReqO[1] && rdGntI[1]) |=> !rdReqO[1]);

  // R4
  req_a_stay_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyO && !rdReqO[0]) |=> !rdReqO[0]);

  // R4
  req_b_stay_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyO && !rdReqO[1]) |=> !rdReqO[1]);

  // R6
  wr_after_reads_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrReqO |-> (rdReqO == 2'b00));

  // R7
  result_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrGntI && wrReqO) |-> (resultO == '0));

  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrGntI && wrReqO) |=> (!busyO && !wrReqO));

  // R9
  zero_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (issueI && !busyO && zeroAI) |=> !rdReqO[0]);

  // R2
  issue_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyO && !(wrGntI && wrReqO)) |=> busyO);

endmodule

bind opCompUnit opcu_chk #(.W(W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .issueI  (issueI),
  .zeroAI  (zeroAI),
  .busyO   (busyO),
  .rdReqO  (rdReqO),
  .rdGntI  (rdGntI),
  .wrReqO  (wrReqO),
  .wrGntI  (wrGntI),
  .resultO (resultO)
);

// File: tb/opCompUnit_tb.sv
module opCompUnit_tb_top;
  localparam int W = 16;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         issueI = 1'b0;
  logic [1:0]   opI = 2'b00;
  logic         zeroAI = 1'b0;
  logic         busyO;
  logic [1:0]   rdReqO;
  logic [1:0]   rdGntI = 2'b00;
  logic [W-1:0] srcAI = '0;
  logic [W-1:0] srcBI = '0;
  logic         wrReqO;
  logic         wrGntI = 1'b0;
  logic [W-1:0] resultO;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opCompUnit #(.W(W)) dut_i (
    .clk(clk), .rstN(rstN), .issueI(issueI), .opI(opI), .zeroAI(zeroAI),
    .busyO(busyO), .rdReqO(rdReqO), .rdGntI(rdGntI), .srcAI(srcAI),
    .srcBI(srcBI), .wrReqO(wrReqO), .wrGntI(wrGntI), .resultO(resultO)
  );

  function automatic logic [W-1:0] expAlu(logic [1:0] op, logic [W-1:0] a, logic [W-1:0] b);
    case (op)
      2'b00: return a + b;
      2'b01: return a - b;
      2'b10: return a & b;
      default: return a | b;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one full operation; delays count cycles from the first cycle of busy
  task automatic runOp(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input bit zero, input int dA, input int dB, input int dW,
                       input bit spur, input bit lateIssue);
    int lastCap;
    int wc;
    logic [W-1:0] effA;
    effA = zero ? '0 : a;
    lastCap = zero ? dB : ((dA > dB) ? dA : dB);
    wc = lastCap + 1 + dW;
    @(negedge clk);
    issueI = 1'b1; opI = op; zeroAI = zero;
    @(negedge clk);
    issueI = 1'b0; opI = 2'($urandom); zeroAI = 1'($urandom);
    check(busyO == 1'b1, "R1 busy after issue", 32'(busyO), 32'd1);
    for (int c = 0; c <= wc; c++) begin
      check(rdReqO[0] == (!zero && c <= dA), zero ? "R9 rdReq A stays low" : "R4 rdReq A",
            32'(rdReqO[0]), 32'(!zero && c <= dA));
      check(rdReqO[1] == (c <= dB), "R4 rdReq B", 32'(rdReqO[1]), 32'(c <= dB));
      check(wrReqO == (c > lastCap), "R6 wrReq timing", 32'(wrReqO), 32'(c > lastCap));
      check(busyO == 1'b1, "R8 busy held", 32'(busyO), 32'd1);
      check(resultO == '0, "R7 result idle", 32'(resultO), 32'd0);
      // read grants (R3, R5), spurious ones (R10)
      srcAI = W'($urandom); srcBI = W'($urandom);
      if (!zero && c == dA) begin rdGntI[0] = 1'b1; srcAI = a; end
      else if (spur && (zero || c > dA) && $urandom_range(1, 0) == 1) rdGntI[0] = 1'b1;
      if (c == dB) begin rdGntI[1] = 1'b1; srcBI = b; end
      else if (spur && c > dB && $urandom_range(1, 0) == 1) rdGntI[1] = 1'b1;
      if (c == wc) wrGntI = 1'b1;
      if (lateIssue && (c == wc || c == 0)) begin issueI = 1'b1; opI = ~op; zeroAI = ~zero; end
      if (c == wc) begin
        #1;
        check(resultO == expAlu(op, effA, b), "R7 result in write grant cycle",
              32'(resultO), 32'(expAlu(op, effA, b)));
      end
      @(negedge clk);
      rdGntI = 2'b00; wrGntI = 1'b0; issueI = 1'b0;
    end
    check(busyO == 1'b0, "R8 busy released", 32'(busyO), 32'd0);
    check(wrReqO == 1'b0, "R8 wrReq released", 32'(wrReqO), 32'd0);
    check(rdReqO == 2'b00, "R4 reqs low after op", 32'(rdReqO), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(busyO == 1'b0 && rdReqO == 2'b00 && wrReqO == 1'b0 && resultO == '0,
          "R1 reset state idle", {busyO, rdReqO, wrReqO}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    // R5 both grants in first cycle
    runOp(2'b00, 16'h1234, 16'h0101, 1'b0, 0, 0, 0, 1'b0, 1'b0);
    // R5 B before A
    runOp(2'b01, 16'h0005, 16'h0003, 1'b0, 3, 0, 1, 1'b0, 1'b0);
    // R7 add wrap and sub borrow
    runOp(2'b00, 16'hFFFF, 16'h0001, 1'b0, 1, 2, 0, 1'b0, 1'b0);
    runOp(2'b01, 16'h0000, 16'h0001, 1'b0, 2, 2, 2, 1'b0, 1'b0);
    // R9 zero immediate with spurious A grants (R10)
    runOp(2'b11, 16'hABCD, 16'h00F0, 1'b1, 0, 1, 0, 1'b1, 1'b0);
    // R2 issue during busy and in write grant cycle
    runOp(2'b10, 16'hF0F0, 16'h3C3C, 1'b0, 1, 0, 1, 1'b1, 1'b1);
    for (int i = 0; i < 300; i++) begin
      runOp(2'($urandom), W'($urandom), W'($urandom), ($urandom_range(3, 0) == 0),
            $urandom_range(3, 0), $urandom_range(3, 0), $urandom_range(3, 0),
            1'($urandom), 1'($urandom));
      if ($urandom_range(1, 0) == 1) @(negedge clk);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule